// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns the address a DMA device presents into a physical memory address. The translation comes from a flat table of entries held in main memory. The host programs two registers: the table's start address and its length in bytes. For each request the block splits the address into a page number and an in-page offset. It rejects any page number beyond the table length, and otherwise fetches the matching table entry with a single 8-byte read. The result carries a permission flag. When the flag is set, the result holds the frame from the entry with the original offset appended. When it is clear, the result is a fault with a zero address.

Only one translation is in flight at a time. The request port drops its ready while a lookup is pending. The memory side uses a valid/ready request channel and a response strobe that carries the entry data and an error bit. In each 8-byte entry the frame is the first 32-bit word and an owner word follows it. Only the frame word is used.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset the table start and length registers both read zero, `req_ready` is high and `res_valid` is low, so the first lookup faults.
- R2: The low PAGE_BITS (default 12) bits of the request address appear unchanged in the low bits of a successful translated address.
- R3: A lookup proceeds only when the page number (address shifted right by PAGE_BITS) is strictly less than the length register shifted right by 3. Any other lookup faults with `res_perm` 0 and `res_addr` 0, and issues no memory read.
- R4: The entry read address is the start register with bit 31 forced to 0, plus 8 times the page number, wrapping modulo 2^32. It is held steady until `mem_req_ready` accepts it.
- R5: On a good response the upper bits of `res_addr` are bits 31..PAGE_BITS of `mem_rsp_data[31:0]` (the frame word), and `res_perm` is 1. The low bits of the frame and the owner word in `mem_rsp_data[63:32]` have no effect.
- R6: A response with `mem_rsp_err` set gives a fault: `res_perm` 0 and `res_addr` 0.
- R7: Register selector 0 is the table start and selector 1 is the table length. Both are written with `reg_we` and read back combinationally on `reg_rdata`. Selector 2 is an invalidate slot: writing it changes neither register, and reading it returns zero.
- R8: From acceptance until the result pulse, `req_ready` stays low. It is high again in the cycle in which `res_valid` is high.
- R9: A bounds fault shows on `res_valid` in the cycle right after acceptance. A table hit shows in the cycle right after the response strobe is sampled. `res_valid` is a one-cycle pulse per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register selector (0 start, 1 length, 2 invalidate) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Device-side address to translate |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the entry read |
| mem_req_addr | output | 32 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data strobe |
| mem_rsp_data | input | 64 | Entry: frame in [31:0], owner in [63:32] |
| mem_rsp_err | input | 1 | Entry read failed |
| res_valid | output | 1 | Result pulse |
| res_addr | output | 32 | Translated address, zero on a fault |
| res_perm | output | 1 | 1 grants read/write, 0 is a fault |

## Verification
The bench builds the block with the default PAGE_BITS of 12. With that value a length register up to 512 bytes covers a 64-entry table model, so every in-range page and the first out-of-range pages can be reached with small addresses. Length values that are not multiples of 8 exercise the rounding-down comparison at its edge. A start address with bit 31 set, and a second table placement, show that the top bit is ignored in the entry address.

// File: rtl/dma_page_xlate.sv
module dma_page_xlate #(
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        res_valid,
  output logic [31:0] res_addr,
  output logic        res_perm
);
  localparam int IDX_W = 32 - PAGE_BITS;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t               state_q;
  logic [31:0]          base_q, limit_q, entry_q;
  logic [PAGE_BITS-1:0] off_q;

  wire [IDX_W-1:0] page_idx   = req_addr[31:PAGE_BITS];
  wire [31:0]      n_entries  = {3'b000, limit_q[31:3]};
  wire             in_range   = 32'(page_idx) < n_entries;
  wire [31:0]      entry_addr = {1'b0, base_q[30:0]} + 32'({page_idx, 3'b000});
  wire             accept     = req_valid && req_ready;

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = entry_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = limit_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == 2'd0) base_q  <= reg_wdata;
      if (reg_addr == 2'd1) limit_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      entry_q   <= '0;
      off_q     <= '0;
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_perm  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          off_q   <= req_addr[PAGE_BITS-1:0];
          entry_q <= entry_addr;
          if (in_range) begin
            state_q <= S_ISSUE;
          end else begin
            res_valid <= 1'b1;
            res_addr  <= '0;
            res_perm  <= 1'b0;
          end
        end
        S_ISSUE: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          state_q   <= S_IDLE;
          res_valid <= 1'b1;
          res_perm  <= !mem_rsp_err;
          res_addr  <= mem_rsp_err ? '0 : {mem_rsp_data[31:PAGE_BITS], off_q};
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_page_xlate_checks.sv
module dma_page_xlate_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        res_valid,
  input logic [31:0] res_addr,
  input logic        res_perm,
  input logic [31:0] base_q,
  input logic [31:0] limit_q
);
  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_perm |-> res_addr == 32'd0);

  assert_idle_on_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);

  assert_busy_while_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_hold_entry_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_result_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && !req_ready && !mem_req_valid |=> res_valid && req_ready);

  assert_invalidate_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd2 |=> $stable(base_q) && $stable(limit_q));
endmodule

bind dma_page_xlate dma_page_xlate_checks u_chk (.*);

// File: tb/sim_dma_page_xlate.sv
`timescale 1ns/1ps
module sim_dma_page_xlate;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_addr = 0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [63:0] mem_rsp_data = 0;
  logic        res_valid, res_perm;
  logic [31:0] res_addr;

  always #4 clk = ~clk;

  dma_page_xlate u0 (.*);

  int tests = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] tframe [64];
  logic [31:0] towner [64];
  bit          terr   [64];
  logic [31:0] tbl_loc = 32'h1000;
  logic [31:0] cur_base = 0, cur_limit = 0;

  int          mem_cnt = 0;
  logic [31:0] last_mem_addr = 0;
  int          rsp_cyc = 0;
  bit          pend = 0;
  int          dly = 0;
  logic [31:0] pend_addr = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : mem_model
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        mem_req_ready = 0;
        if (dly == 0) begin
          logic [31:0] rel;
          int k;
          rel = pend_addr - tbl_loc;
          k = int'(rel >> 3);
          mem_rsp_valid = 1;
          if (pend_addr >= tbl_loc && rel < 32'd512 && rel[2:0] == 0) begin
            mem_rsp_data = {towner[k], tframe[k]};
            mem_rsp_err  = terr[k];
          end else begin
            mem_rsp_data = {$urandom, $urandom};
            mem_rsp_err  = 1;
          end
          rsp_cyc = cyc;
          pend = 0;
        end else dly--;
      end else begin
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
          pend = 1;
          pend_addr = mem_req_addr;
          last_mem_addr = mem_req_addr;
          mem_cnt++;
          dly = $urandom % 3;
        end
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 0) cur_base = d;
    if (a == 1) cur_limit = d;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  function automatic bit exp_hit(logic [31:0] va);
    return (va >> 12) < (cur_limit >> 3);
  endfunction

  task automatic lookup(logic [31:0] va, string req);
    bit hit, err, busy_ok;
    int idx, start_cnt, acc_cyc, waited;
    logic [31:0] eaddr, exp_addr;
    hit = exp_hit(va);
    idx = int'(va >> 12);
    eaddr = {1'b0, cur_base[30:0]} + (va >> 12) * 8;
    err = hit ? (eaddr == tbl_loc + 32'(idx * 8) && idx < 64 ? terr[idx & 63] : 1'b1) : 1'b1;
    exp_addr = (hit && !err) ? {tframe[idx & 63][31:12], va[11:0]} : 32'd0;
    start_cnt = mem_cnt;
    @(negedge clk);
    req_valid = 1; req_addr = va;
    waited = 0;
    while (!req_ready && waited < 50) begin @(negedge clk); waited++; end
    @(negedge clk);
    req_valid = 0;
    acc_cyc = cyc;
    busy_ok = 1;
    waited = 0;
    while (!res_valid && waited < 60) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      waited++;
    end
    chk(res_valid, {req, " result pulse R9"}, 32'(res_valid), 1);
    chk(res_addr == exp_addr, {req, " address"}, res_addr, exp_addr);
    chk(res_perm == (hit && !err), {req, " permission"}, 32'(res_perm), 32'(hit && !err));
    chk(busy_ok && req_ready, {req, " busy R8"}, 32'(busy_ok), 1);
    if (hit) begin
      chk(mem_cnt == start_cnt + 1, {req, " one read R4"}, 32'(mem_cnt - start_cnt), 1);
      chk(last_mem_addr == eaddr, {req, " entry address R4"}, last_mem_addr, eaddr);
      chk(cyc == rsp_cyc + 1, {req, " hit timing R9"}, 32'(cyc), 32'(rsp_cyc + 1));
    end else begin
      chk(mem_cnt == start_cnt, {req, " no read R3"}, 32'(mem_cnt - start_cnt), 0);
      chk(cyc == acc_cyc, {req, " fault timing R9"}, 32'(cyc), 32'(acc_cyc));
    end
    @(negedge clk);
    chk(!res_valid, {req, " single pulse R9"}, 32'(res_valid), 0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4030));
    for (int i = 0; i < 64; i++) begin
      tframe[i] = $urandom;
      towner[i] = $urandom;
      terr[i]   = 0;
    end
    terr[5] = 1;
    terr[40] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !res_valid, "R1 idle after reset", {30'd0, req_ready, res_valid}, 32'h2);
    rd_chk(0, 0, "R1 start reg zero");
    rd_chk(1, 0, "R1 length reg zero");
    lookup(32'h0000_0123, "R1 first lookup faults");

    wr(0, 32'h8000_1000);
    rd_chk(0, 32'h8000_1000, "R7 start readback");
    wr(1, 32'd8);
    rd_chk(1, 32'd8, "R7 length readback");
    lookup(32'h0000_0abc, "R2 R5 page 0 hit");
    lookup(32'h0000_1abc, "R3 page 1 beyond length 8");
    wr(1, 32'd15);
    lookup(32'h0000_1000, "R3 length 15 rounds down");
    wr(1, 32'd16);
    lookup(32'h0000_1fff, "R3 length 16 admits page 1");
    wr(1, 32'd512);
    lookup(32'h0000_5010, "R6 error entry");
    lookup(32'h0003_f777, "R3 last page 63");
    lookup(32'h0004_0000, "R3 page 64 out");
    tframe[7] = 32'hdead_bfff;
    lookup(32'h0000_7001, "R5 frame low bits dropped");

    @(negedge clk);
    reg_we = 1; reg_addr = 2; reg_wdata = 32'hffff_ffff;
    @(negedge clk);
    reg_we = 0;
    rd_chk(0, 32'h8000_1000, "R7 invalidate keeps start");
    rd_chk(1, 32'd512, "R7 invalidate keeps length");
    rd_chk(2, 32'd0, "R7 invalidate reads zero");

    tbl_loc = 32'h0002_0000;
    wr(0, 32'h0002_0000);
    lookup(32'h0000_3456, "R4 moved table");

    for (int n = 0; n < 200; n++) begin
      if (($urandom % 10) == 0) wr(1, $urandom % 560);
      lookup({12'h0, 8'($urandom % 72), 12'($urandom)}, "R3 R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule